// File: doc/BRIEF.md
# H-Bridge Control and Fault Supervisor

This block sits between two command pins and the gate drivers of a four-switch H-bridge. The 2-bit command, taken from `cmd_a` and `cmd_b`, selects one of four states: forward drive, reverse drive, brake with both low-side switches on, or all switches off. The block produces one enable for each of the four switches. A per-leg interlock makes sure the high-side and low-side switch of the same leg are never enabled together.

The block also supervises the bridge. It watches per-switch overcurrent flags, output-short flags, a short across the load, an overtemperature trip/release pair and a pair of open-load comparators. A fault must stay present for a qualification window of `QUAL_US` microseconds, counted in clock cycles derived from `CLK_HZ`. After that window the block turns every switch off and drives an active-low error flag, together with an enable for an open-drain pull-down. Any change of the command clears the fault. The exception is a qualified short across the load, which only reset clears. An undervoltage flag turns every switch off at once and does not raise the error flag.

Top module: `hbridge_supervisor`

## Requirements
- R1: While reset is asserted and right after it, all four switch enables are 0, `err_n` is 1 and `flag_pull` is 0.
- R2: The command code {cmd_a, cmd_b} selects the switches. Index 0 is the OUT1 leg and index 1 is the OUT2 leg. Code 00 gives hs_en=01, ls_en=10. Code 01 gives hs_en=10, ls_en=01. Code 10 gives hs_en=00, ls_en=11. Code 11 gives hs_en=00, ls_en=00.
- R3: The command passes through a two-flop synchronizer. A change on the pins shows at the enables after the second rising clock edge, and not after the first.
- R4: Any fault source held for QUAL_CYC consecutive rising edges latches the fault. A source held for only QUAL_CYC-1 edges does not latch it. A one-cycle gap in the fault restarts the count.
- R5: While the fault is latched, all four enables are 0, `err_n` is 0 and `flag_pull` is 1.
- R6: Open load is counted only while the synchronized command is 11 and `ol_hi` and `ol_lo` are both 1. In any other command, or with only one of them high, the open-load inputs have no effect.
- R7: A change of the synchronized command clears a latched fault and restarts the qualification count on the third edge after the pin change. If the fault is still present, it latches again QUAL_CYC edges later.
- R8: A fault that qualifies while `load_short` is 1 becomes sticky. A command change does not clear it; only reset does.
- R9: A one-cycle pulse on `ot_trip` holds the overtemperature condition until `ot_release` is seen. That held condition feeds the same qualification path as the other faults.
- R10: While `uv_active` is 1, all four enables are 0 in the same cycle. The error flag is not raised, and drive returns as soon as `uv_active` drops.
- R11: In no cycle are `hs_en[i]` and `ls_en[i]` both 1 for the same leg.
- R12: Overcurrent on any switch, a short to ground and a short to supply on either leg each latch the fault through the same qualification window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_a | input | 1 | Command bit, MSB of the code, asynchronous |
| cmd_b | input | 1 | Command bit, LSB of the code, asynchronous |
| oc_hs | input | 2 | Overcurrent flag per high-side switch |
| oc_ls | input | 2 | Overcurrent flag per low-side switch |
| gnd_short | input | 2 | Output shorted to ground, per leg |
| sup_short | input | 2 | Output shorted to supply, per leg |
| load_short | input | 1 | Short between the two outputs |
| ol_hi | input | 1 | OUT1 reads near supply |
| ol_lo | input | 1 | OUT2 reads near ground |
| ot_trip | input | 1 | Temperature above trip level |
| ot_release | input | 1 | Temperature below re-enable level |
| uv_active | input | 1 | Supply undervoltage present |
| hs_en | output | 2 | High-side switch enables, per leg |
| ls_en | output | 2 | Low-side switch enables, per leg |
| err_n | output | 1 | Active-low error flag |
| flag_pull | output | 1 | Enable for the open-drain flag pull-down |

## Verification
The assertions assume that the fault-status inputs and `uv_active` are already synchronous to `clk`; only the command pins are synchronized inside the block. They also assume that `ot_trip` wins when both temperature flags are high. The bench changes every input on the falling edge, so all inputs are stable at the sampling edge. It never raises `ot_trip` and `ot_release` together. For the load-short check, the bench lowers `load_short` before it changes the command. This shows that the stickiness comes from the latch and not from the input still being present.

// File: rtl/hbs_pkg.sv
`timescale 1ns/1ps
package hbs_pkg;

   typedef enum logic [1:0] {
      CMD_FWD = 2'b00,
      CMD_REV = 2'b01,
      CMD_BRK = 2'b10,
      CMD_OFF = 2'b11
   } hb_cmd_e;

   typedef struct packed {
      logic [1:0] hs;
      logic [1:0] ls;
   } hb_sw_t;

   function automatic hb_sw_t decode_cmd(input hb_cmd_e c);
      hb_sw_t s;
      s = '0;
      case (c)
         CMD_FWD: begin s.hs = 2'b01; s.ls = 2'b10; end
         CMD_REV: begin s.hs = 2'b10; s.ls = 2'b01; end
         CMD_BRK: begin s.hs = 2'b00; s.ls = 2'b11; end
         default: begin s.hs = 2'b00; s.ls = 2'b00; end
      endcase
      return s;
   endfunction

endpackage

// File: rtl/hbs_sync.sv
`timescale 1ns/1ps
module hbs_sync #(
   parameter int                W       = 2,
   parameter int                STAGES  = 2,
   parameter logic [W-1:0]      RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hbs_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("hbs_sync: W must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {STAGES{RST_VAL}};
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/hbs_qual_timer.sv
`timescale 1ns/1ps
module hbs_qual_timer #(
   parameter int QUAL_CYC = 2500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic raw,
   output logic expire
);

   generate
      if (QUAL_CYC < 2) begin : g_bad_qual
         $error("hbs_qual_timer: QUAL_CYC must be at least 2");
      end
   endgenerate

   localparam int              CNT_W = $clog2(QUAL_CYC);
   localparam logic [CNT_W-1:0] TERM = CNT_W'(QUAL_CYC - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (clr || !raw)       cnt_q <= '0;
      else if (cnt_q != TERM)     cnt_q <= cnt_q + 1'b1;
   end

   assign expire = raw && !clr && (cnt_q == TERM);

   // R4
   qual_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= TERM);

   // R4
   qual_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0) |-> $past(raw));

endmodule

// File: rtl/hbs_interlock.sv
`timescale 1ns/1ps
module hbs_interlock #(
   parameter int LEGS = 2
) (
   input  logic [LEGS-1:0] req_hs,
   input  logic [LEGS-1:0] req_ls,
   input  logic            kill,
   output logic [LEGS-1:0] hs_o,
   output logic [LEGS-1:0] ls_o
);

   generate
      if (LEGS < 1) begin : g_bad_legs
         $error("hbs_interlock: LEGS must be at least 1");
      end
      for (genvar i = 0; i < LEGS; i++) begin : g_leg
         always_comb begin
            hs_o[i] = req_hs[i] && !req_ls[i] && !kill;
            ls_o[i] = req_ls[i] && !req_hs[i] && !kill;
         end
      end
   endgenerate

endmodule

// File: rtl/hbridge_supervisor.sv
`timescale 1ns/1ps
module hbridge_supervisor
   import hbs_pkg::*;
#(
   parameter int CLK_HZ      = 50_000_000,
   parameter int QUAL_US     = 50,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_a,
   input  logic       cmd_b,
   input  logic [1:0] oc_hs,
   input  logic [1:0] oc_ls,
   input  logic [1:0] gnd_short,
   input  logic [1:0] sup_short,
   input  logic       load_short,
   input  logic       ol_hi,
   input  logic       ol_lo,
   input  logic       ot_trip,
   input  logic       ot_release,
   input  logic       uv_active,
   output logic [1:0] hs_en,
   output logic [1:0] ls_en,
   output logic       err_n,
   output logic       flag_pull
);

   localparam int QUAL_CYC = (CLK_HZ / 1_000_000) * QUAL_US;

   generate
      if (CLK_HZ < 1_000_000) begin : g_bad_clk
         $error("hbridge_supervisor: CLK_HZ must be at least 1 MHz");
      end
      if (QUAL_CYC < 2) begin : g_bad_window
         $error("hbridge_supervisor: qualification window below 2 cycles");
      end
   endgenerate

   // command path
   logic [1:0] cmd_s;
   logic [1:0] cmd_q;
   logic       cmd_chg;
   hb_cmd_e    mode;

   hbs_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cmd_a, cmd_b}),
      .q     (cmd_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmd_q <= 2'b11;
      else        cmd_q <= cmd_s;
   end

   assign mode    = hb_cmd_e'(cmd_s);
   assign cmd_chg = (cmd_s != cmd_q);

   // overtemperature hysteresis state
   logic hot_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          hot_q <= 1'b0;
      else if (ot_trip)    hot_q <= 1'b1;
      else if (ot_release) hot_q <= 1'b0;
   end

   // fault gathering
   logic open_load;
   logic raw_fault;
   assign open_load = (mode == CMD_OFF) && ol_hi && ol_lo;
   assign raw_fault = (|oc_hs) || (|oc_ls) || (|gnd_short) || (|sup_short)
                    || load_short || hot_q || open_load;

   // qualification and latch
   logic fault_lat;
   logic sticky_q;
   logic expire;
   logic clr_req;

   assign clr_req = cmd_chg && !sticky_q;

   hbs_qual_timer #(.QUAL_CYC(QUAL_CYC)) u_qual (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr_req),
      .raw    (raw_fault),
      .expire (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_lat <= 1'b0;
         sticky_q  <= 1'b0;
      end else if (clr_req) begin
         fault_lat <= 1'b0;
      end else if (expire) begin
         fault_lat <= 1'b1;
         if (load_short) sticky_q <= 1'b1;
      end
   end

   // switch drive
   hb_sw_t sw_req;
   assign sw_req = decode_cmd(mode);

   hbs_interlock #(.LEGS(2)) u_ilk (
      .req_hs (sw_req.hs),
      .req_ls (sw_req.ls),
      .kill   (fault_lat || uv_active),
      .hs_o   (hs_en),
      .ls_o   (ls_en)
   );

   assign err_n     = !fault_lat;
   assign flag_pull = fault_lat;

   // R4
   latch_after_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_lat) |-> $past(raw_fault));

   // R5
   off_when_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !err_n |-> (hs_en == 2'b00 && ls_en == 2'b00 && flag_pull));

   // R7
   clear_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_chg && !sticky_q) |=> !fault_lat);

   // R8
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sticky_q |=> (sticky_q && fault_lat));

   // R10
   uv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uv_active |-> (hs_en == 2'b00 && ls_en == 2'b00));

   // R11
   no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_en & ls_en) == 2'b00);

endmodule

// File: tb/sim_hbridge_supervisor.sv
`timescale 1ns/1ps
module sim_hbridge_supervisor;

   localparam int Q = 50;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_a = 1'b1, cmd_b = 1'b1;
   logic [1:0] oc_hs = '0, oc_ls = '0, gnd_short = '0, sup_short = '0;
   logic load_short = 0, ol_hi = 0, ol_lo = 0, ot_trip = 0, ot_release = 0, uv_active = 0;
   logic [1:0] hs_en, ls_en;
   logic err_n, flag_pull;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   always #10 clk = ~clk;

   hbridge_supervisor #(.CLK_HZ(1_000_000), .QUAL_US(Q), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_a(cmd_a), .cmd_b(cmd_b),
      .oc_hs(oc_hs), .oc_ls(oc_ls), .gnd_short(gnd_short), .sup_short(sup_short),
      .load_short(load_short), .ol_hi(ol_hi), .ol_lo(ol_lo),
      .ot_trip(ot_trip), .ot_release(ot_release), .uv_active(uv_active),
      .hs_en(hs_en), .ls_en(ls_en), .err_n(err_n), .flag_pull(flag_pull)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   function automatic logic [5:0] obs();
      return {hs_en, ls_en, err_n, flag_pull};
   endfunction

   function automatic logic [5:0] drive_pat(input logic [1:0] c);
      case (c)
         2'b00:   return 6'b0110_10;
         2'b01:   return 6'b1001_10;
         2'b10:   return 6'b0011_10;
         default: return 6'b0000_10;
      endcase
   endfunction

   localparam logic [5:0] FAULTED = 6'b0000_01;

   task automatic clear_inputs();
      oc_hs = '0; oc_ls = '0; gnd_short = '0; sup_short = '0;
      load_short = 0; ol_hi = 0; ol_lo = 0; ot_trip = 0; ot_release = 0; uv_active = 0;
   endtask

   task automatic do_reset(input logic [1:0] c);
      clear_inputs();
      {cmd_a, cmd_b} = c;
      rst_n = 0;
      tick(2);
      rst_n = 1;
      tick(4);
   endtask

   task automatic set_cmd(input logic [1:0] c);
      {cmd_a, cmd_b} = c;
      tick(3);
   endtask

   task automatic t_reset();
      clear_inputs();
      {cmd_a, cmd_b} = 2'b00;
      rst_n = 0;
      tick(2);
      check("R1 in reset", obs(), 6'b0000_10);
      rst_n = 1;
      #1 check("R1 after reset", obs(), 6'b0000_10);
      tick(4);
   endtask

   task automatic t_modes();
      do_reset(2'b11);
      for (int c = 0; c < 4; c++) begin
         set_cmd(2'(c));
         check($sformatf("R2 code %0d", c), obs(), drive_pat(2'(c)));
         check($sformatf("R11 code %0d", c), {2'b00, hs_en & ls_en, 2'b00}, 6'b0);
      end
   endtask

   task automatic t_sync();
      do_reset(2'b00);
      {cmd_a, cmd_b} = 2'b10;
      tick(1);
      check("R3 after one edge", obs(), drive_pat(2'b00));
      tick(1);
      check("R3 after two edges", obs(), drive_pat(2'b10));
   endtask

   task automatic t_qual();
      do_reset(2'b00);
      oc_hs[0] = 1;
      tick(Q - 1);
      check("R4 one edge short", obs(), drive_pat(2'b00));
      tick(1);
      check("R4 R5 latched", obs(), FAULTED);
   endtask

   task automatic t_break();
      do_reset(2'b01);
      oc_ls[1] = 1;
      tick(Q - 1);
      oc_ls[1] = 0;
      tick(1);
      oc_ls[1] = 1;
      tick(Q - 1);
      check("R4 gap restarts count", obs(), drive_pat(2'b01));
      tick(1);
      check("R4 latched after full window", obs(), FAULTED);
   endtask

   task automatic t_clear();
      do_reset(2'b00);
      gnd_short[0] = 1;
      tick(Q);
      check("R7 latched", obs(), FAULTED);
      gnd_short[0] = 0;
      {cmd_a, cmd_b} = 2'b01;
      tick(2);
      check("R7 not yet cleared", obs(), FAULTED);
      tick(1);
      check("R7 cleared by change", obs(), drive_pat(2'b01));
      sup_short[1] = 1;
      tick(Q);
      check("R12 supply short latched", obs(), FAULTED);
      {cmd_a, cmd_b} = 2'b10;
      tick(3);
      check("R7 cleared with fault present", obs(), drive_pat(2'b10));
      tick(Q - 1);
      check("R7 relatch pending", obs(), drive_pat(2'b10));
      tick(1);
      check("R7 relatched", obs(), FAULTED);
   endtask

   task automatic t_sources();
      for (int k = 0; k < 8; k++) begin
         do_reset(2'b00);
         case (k)
            0: oc_hs[0] = 1;     1: oc_hs[1] = 1;
            2: oc_ls[0] = 1;     3: oc_ls[1] = 1;
            4: gnd_short[1] = 1; 5: sup_short[0] = 1;
            6: gnd_short[0] = 1; default: sup_short[1] = 1;
         endcase
         tick(Q);
         check($sformatf("R12 source %0d", k), obs(), FAULTED);
      end
   endtask

   task automatic t_open_load();
      do_reset(2'b00);
      ol_hi = 1; ol_lo = 1;
      tick(Q + 10);
      check("R6 ignored in forward", obs(), drive_pat(2'b00));
      ol_hi = 0; ol_lo = 0;
      set_cmd(2'b11);
      ol_hi = 1;
      tick(Q + 10);
      check("R6 one comparator only", obs(), drive_pat(2'b11));
      ol_lo = 1;
      tick(Q - 1);
      check("R6 pending", obs(), drive_pat(2'b11));
      tick(1);
      check("R6 open load latched", obs(), FAULTED);
   endtask

   task automatic t_load_short();
      do_reset(2'b10);
      load_short = 1;
      tick(Q);
      check("R8 latched", obs(), FAULTED);
      load_short = 0;
      set_cmd(2'b00);
      tick(Q + 5);
      check("R8 survives change", obs(), FAULTED);
      rst_n = 0;
      tick(2);
      rst_n = 1;
      tick(4);
      check("R8 reset clears", obs(), drive_pat(2'b00));
   endtask

   task automatic t_overtemp();
      do_reset(2'b01);
      ot_trip = 1;
      tick(1);
      ot_trip = 0;
      tick(Q + 3);
      check("R9 trip held", obs(), FAULTED);
      ot_release = 1;
      tick(1);
      ot_release = 0;
      set_cmd(2'b00);
      tick(Q + 5);
      check("R9 released stays clear", obs(), drive_pat(2'b00));
   endtask

   task automatic t_uv();
      do_reset(2'b00);
      uv_active = 1;
      #1 check("R10 immediate off", obs(), 6'b0000_10);
      tick(Q + 5);
      check("R10 no flag", obs(), 6'b0000_10);
      uv_active = 0;
      #1 check("R10 drive returns", obs(), drive_pat(2'b00));
      tick(1);
   endtask

   initial begin
      t_reset();
      t_modes();
      t_sync();
      t_qual();
      t_break();
      t_clear();
      t_sources();
      t_open_load();
      t_load_short();
      t_overtemp();
      t_uv();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150_000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=expired expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule